// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block runs clause-22 management transactions towards external PHY devices over a two-wire management pair. It generates the management clock (MDC) and drives the bidirectional data line through three pad signals: output value, output enable and sampled input. Software reaches the block through a small register port that has a register address, a write strobe, write data, a read strobe and registered read data.

Software first chooses an MDC ratio in the configuration register and loads the target PHY and register number into the address register. A write transaction is launched by storing the 16-bit value in the write-data register. A read transaction is launched by setting bit 0 of the command register. Software then polls the busy register until it reads zero, and fetches the returned value from the read-data register.

The block never launches a second frame on top of a running one. A hold bit in the configuration register freezes the clock generator and the serializer.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, the data output enable is low, and the configuration, command, address, write-data, read-data and busy registers all read 0.
- R2: The address register (offset 2) carries the PHY address in bits [15:8] and the register number in bits [7:0]. The frame uses bits [12:8] as the 5-bit PHY address and bits [4:0] as the 5-bit register number.
- R3: A register write to the command register (offset 1) with bit 0 set, made while the block is idle, launches a read frame. A write of 0 to that register launches nothing.
- R4: A register write to the write-data register (offset 3), made while the block is idle, launches a write frame that carries bits [15:0] of the written word. The output enable stays high for all 64 bits of a write frame.
- R5: The busy register (offset 5) reads 1 from the cycle after a trigger until the frame ends and reads 0 when the block is idle. A frame lasts exactly 64×N system cycles, where N is the MDC ratio.
- R6: When a read frame completes, the 16 data bits sampled from the input appear in bits [15:0] of the read-data register (offset 4), first-received bit as bit 15, with the upper bits zero.
- R7: Configuration bits [2:0] select the MDC ratio: code 0 gives 6, code 1 gives 10, code 2 gives 28, code 3 gives 58, and every other code gives 58.
- R8: While configuration bit 7 is set, no trigger launches a frame and MDC stays low. Setting bit 7 during a frame stops that frame: busy drops and the output enable goes low.
- R9: A frame sends, MSB first, 32 ones, the start pattern 01, the opcode (10 for read, 01 for write), 5 PHY-address bits, 5 register bits, a turnaround (10 for write) and 16 data bits. The data output changes only at the MDC falling edge.
- R10: In a read frame, the output enable is high for the first 46 bits and low from the turnaround through the last data bit. Once any frame ends, the output enable is low.
- R11: While busy, writes to the command and write-data registers are ignored. Their stored values are kept, the running frame is not altered, and no further frame follows it.
- R12: MDC toggles only while a frame is active, gives exactly 64 rising edges per frame, and is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_re | input | 1 | Register read strobe; data is returned on the next cycle |
| reg_rdata | output | 16 | Registered read data |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
Each ratio code, including an out-of-range code, is checked against the exact busy length of 64×N cycles. A divider off by one in either half period would stretch or shrink that count. The bench decodes every captured frame bit by bit against a frame it builds itself, using address bytes whose upper bits are set. A design that shifted out unmasked address bits, reversed bit order or mis-coded the opcode or turnaround would therefore miscompare. A read back-drives a known pattern on the falling edges and compares the returned word: sampling on the wrong edge, or releasing the line one bit late, would corrupt it. Retriggers during busy, the command clear after a read, and hold asserted mid-frame are also tested. A design that queued, restarted, or kept clocking after any of these would show extra MDC edges or a changed stored value.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int REG_W     = 16;
    localparam int RA_W      = 3;
    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = 46;
    localparam int DATA_POS  = 48;
    localparam int HALF_W    = 5;
    localparam int SEL_W     = 3;
    localparam int HOLD_BIT  = 7;

    typedef enum logic [RA_W-1:0] {
        RA_CFG = 3'd0,
        RA_CMD = 3'd1,
        RA_ADR = 3'd2,
        RA_WDT = 3'd3,
        RA_RDT = 3'd4,
        RA_BSY = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } xact_t;

    // half of the MDC period, in system cycles
    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return HALF_W'(3);
            3'd1:    return HALF_W'(5);
            3'd2:    return HALF_W'(14);
            default: return HALF_W'(29);
        endcase
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input xact_t x);
        return {32'hFFFF_FFFF, 2'b01,
                (x.rd ? 2'b10 : 2'b01),
                x.phy, x.regn,
                (x.rd ? 2'b11 : 2'b10),
                (x.rd ? 16'hFFFF : x.data)};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_master_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half_m1;
    logic              term;

    assign half_m1  = half_period(sel) - HALF_W'(1);
    assign term     = run && (cnt == half_m1);
    assign rise_stb = term && !mdc;
    assign fall_stb = term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

    // R12
    mdc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_master_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold,
    input  logic                 start,
    input  logic                 start_rd,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 rd_valid,
    output logic [15:0]          rd_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

    logic [FRAME_LEN-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 rd;

    assign mdio_o  = sh[FRAME_LEN-1];
    assign mdio_oe = active && !(rd && (idx >= TA_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            sh       <= '1;
            idx      <= '0;
            rd       <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (hold) begin
                active <= 1'b0;
            end else if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= frame;
                    idx    <= '0;
                    rd     <= start_rd;
                end
            end else begin
                if (rise_stb && rd && (idx >= DAT_IDX))
                    rd_data <= {rd_data[14:0], mdio_i};
                if (fall_stb) begin
                    if (idx == LAST_IDX) begin
                        active   <= 1'b0;
                        rd_valid <= rd;
                    end else begin
                        idx <= idx + IDX_W'(1);
                        sh  <= {sh[FRAME_LEN-2:0], 1'b1};
                    end
                end
            end
        end
    end

    // R10
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mdio_oe);

    // R9
    out_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !fall_stb) |=> $stable(mdio_o));

    // R8
    hold_stop_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> !active);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_re,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic [SEL_W-1:0] cfg_sel;
    logic             cfg_hold;
    logic             cmd_q;
    logic [REG_W-1:0] addr_q;
    logic [REG_W-1:0] wdata_q;
    logic [15:0]      rdata_q;

    logic             busy;
    logic             wr_cmd, wr_wdt, trig_rd, trig_wr, trig;
    xact_t            xact;
    logic             rise_stb, fall_stb;
    logic             rd_valid;
    logic [15:0]      rd_data;
    logic             unused_addr_bits;

    assign unused_addr_bits = ^{addr_q[15:13], addr_q[7:5]};

    assign wr_cmd  = reg_we && (reg_addr == RA_CMD) && !busy;
    assign wr_wdt  = reg_we && (reg_addr == RA_WDT) && !busy;
    assign trig_rd = wr_cmd && reg_wdata[0] && !cfg_hold;
    assign trig_wr = wr_wdt && !cfg_hold;
    assign trig    = trig_rd || trig_wr;

    always_comb begin
        xact.rd   = trig_rd;
        xact.phy  = addr_q[12:8];
        xact.regn = addr_q[4:0];
        xact.data = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_sel  <= '0;
            cfg_hold <= 1'b0;
            cmd_q    <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            if (reg_we && (reg_addr == RA_CFG)) begin
                cfg_sel  <= reg_wdata[SEL_W-1:0];
                cfg_hold <= reg_wdata[HOLD_BIT];
            end
            if (reg_we && (reg_addr == RA_ADR))
                addr_q <= reg_wdata;
            if (wr_cmd)
                cmd_q <= reg_wdata[0];
            if (wr_wdt)
                wdata_q <= reg_wdata;
            if (rd_valid)
                rdata_q <= rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            case (reg_addr)
                RA_CFG:  reg_rdata <= {8'h00, cfg_hold, 4'h0, cfg_sel};
                RA_CMD:  reg_rdata <= {15'h0000, cmd_q};
                RA_ADR:  reg_rdata <= addr_q;
                RA_WDT:  reg_rdata <= wdata_q;
                RA_RDT:  reg_rdata <= rdata_q;
                RA_BSY:  reg_rdata <= {15'h0000, busy};
                default: reg_rdata <= '0;
            endcase
        end
    end

    mdio_mdc_gen u_mdc_gen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy && !cfg_hold),
        .sel      (cfg_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .hold     (cfg_hold),
        .start    (trig),
        .start_rd (trig_rd),
        .frame    (build_frame(xact)),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R5
    busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> busy);

    // R11
    ignore_wdt_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we && (reg_addr == RA_WDT)) |=> $stable(wdata_q));

    // R12
    mdc_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0000;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADR = 3'd2,
                           A_WDT = 3'd3, A_RDT = 3'd4, A_BSY = 3'd5;

    always #4 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: capture on MDC rise, answer on MDC fall
    int          ph_total = 0;
    int          base = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] resp_q = 16'h0000;

    always @(posedge mdc) begin
        if ((ph_total - base) >= 0 && (ph_total - base) < 64) begin
            cap_o[63 - (ph_total - base)]  = mdio_o;
            cap_oe[63 - (ph_total - base)] = mdio_oe;
        end
        ph_total = ph_total + 1;
    end

    always @(negedge mdc) begin
        if ((ph_total - base) >= 48 && (ph_total - base) < 64)
            mdio_i = resp_q[63 - (ph_total - base)];
        else
            mdio_i = 1'b1;
    end

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic poll_busy(output int ones);
        int guard;
        ones = 0;
        guard = 0;
        reg_addr = A_BSY; reg_re = 1'b1;
        while (guard < 8000) begin
            @(negedge clk);
            guard++;
            if (reg_rdata[0]) ones++;
            else if (ones > 0) break;
        end
        reg_re = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [7:0] phy,
                                              input logic [7:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy[4:0], rg[4:0],
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
    endfunction

    task automatic do_write(input logic [7:0] phy, input logic [7:0] rg,
                            input logic [15:0] d, input int ratio);
        int ones;
        reg_wr(A_ADR, {phy, rg});
        base = ph_total;
        reg_wr(A_WDT, d);
        poll_busy(ones);
        chk_eq("R5/R7", "busy length", 64'(ones), 64'(64 * ratio));
        chk_eq("R12", "mdc rises", 64'(ph_total - base), 64'd64);
        chk_eq("R2/R9", "write frame", cap_o, exp_frame(1'b0, phy, rg, d));
        chk_eq("R4", "write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        chk_eq("R10", "oe after frame", 64'(mdio_oe), 64'd0);
        chk_eq("R12", "mdc idle", 64'(mdc), 64'd0);
    endtask

    task automatic do_read(input logic [7:0] phy, input logic [7:0] rg, input logic [15:0] r);
        int ones;
        logic [15:0] v;
        reg_wr(A_CMD, 16'h0000);
        reg_wr(A_ADR, {phy, rg});
        resp_q = r;
        base = ph_total;
        reg_wr(A_CMD, 16'h0001);
        poll_busy(ones);
        chk_eq("R3/R5", "read busy length", 64'(ones), 64'd384);
        reg_rd(A_RDT, v);
        chk_eq("R6", "read result", 64'(v), 64'(r));
        chk_eq("R9", "read header", 64'(cap_o[63:18]), 64'(exp_frame(1'b1, phy, rg, 16'h0) >> 18));
        chk_eq("R10", "read oe", cap_oe, {{46{1'b1}}, 18'h0});
        reg_wr(A_CMD, 16'h0000);
        repeat (20) @(negedge clk);
        reg_rd(A_BSY, v);
        chk_eq("R3", "clear cmd busy", 64'(v), 64'd0);
        chk_eq("R3", "clear cmd no mdc", 64'(ph_total - base), 64'd64);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        int start_cnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_eq("R1", "mdc", 64'(mdc), 64'd0);
        chk_eq("R1", "oe", 64'(mdio_oe), 64'd0);
        for (int a = 0; a < 6; a++) begin
            reg_rd(3'(a), v);
            chk_eq("R1", "reg after reset", 64'(v), 64'd0);
        end

        // write sweep at ratio 6
        for (int i = 0; i < 12; i++) begin
            do_write(8'(8'hE0 + i * 3), 8'(8'hA0 + i * 7),
                     16'(i * 16'h1357) ^ 16'hA5C3, 6);
        end

        // read sweep at ratio 6
        for (int i = 0; i < 12; i++) begin
            do_read(8'(8'h60 + i * 5), 8'(8'hF3 - i * 11),
                    16'(i * 16'h2E1D) ^ 16'h5A3C);
        end

        // R7 divider codes, including an out-of-range code
        reg_wr(A_CFG, 16'h0001); do_write(8'h01, 8'h02, 16'h8001, 10);
        reg_wr(A_CFG, 16'h0002); do_write(8'h1F, 8'h1F, 16'h7FFE, 28);
        reg_wr(A_CFG, 16'h0003); do_write(8'h10, 8'h01, 16'hC3C3, 58);
        reg_wr(A_CFG, 16'h0005); do_write(8'h02, 8'h10, 16'h0F0F, 58);
        reg_wr(A_CFG, 16'h0000);
        reg_rd(A_CFG, v);
        chk_eq("R7", "cfg readback", 64'(v), 64'd0);

        // R11 triggers while busy are ignored
        reg_wr(A_ADR, 16'h0304);
        base = ph_total;
        reg_wr(A_WDT, 16'h1234);
        repeat (40) @(negedge clk);
        reg_wr(A_WDT, 16'hBEEF);
        reg_wr(A_CMD, 16'h0001);
        repeat (500) @(negedge clk);
        chk_eq("R11", "frame kept", cap_o, exp_frame(1'b0, 8'h03, 8'h04, 16'h1234));
        chk_eq("R11", "no extra frame", 64'(ph_total - base), 64'd64);
        reg_rd(A_WDT, v);
        chk_eq("R11", "wdata kept", 64'(v), 64'h1234);
        reg_rd(A_CMD, v);
        chk_eq("R11", "cmd kept", 64'(v), 64'd0);
        reg_rd(A_BSY, v);
        chk_eq("R11", "idle after", 64'(v), 64'd0);

        // R8 hold bit blocks triggers
        reg_wr(A_CFG, 16'h0080);
        start_cnt = ph_total;
        reg_wr(A_WDT, 16'h5555);
        reg_wr(A_CMD, 16'h0001);
        repeat (100) @(negedge clk);
        reg_rd(A_BSY, v);
        chk_eq("R8", "hold blocks busy", 64'(v), 64'd0);
        chk_eq("R8", "hold blocks mdc", 64'(ph_total - start_cnt), 64'd0);
        reg_wr(A_CMD, 16'h0000);

        // R8 hold aborts a running frame
        reg_wr(A_CFG, 16'h0000);
        reg_wr(A_WDT, 16'h6666);
        repeat (100) @(negedge clk);
        reg_wr(A_CFG, 16'h0080);
        reg_rd(A_BSY, v);
        chk_eq("R8", "abort busy", 64'(v), 64'd0);
        chk_eq("R8", "abort oe", 64'(mdio_oe), 64'd0);
        chk_eq("R8", "abort mdc", 64'(mdc), 64'd0);
        start_cnt = ph_total;
        repeat (50) @(negedge clk);
        chk_eq("R12", "no mdc after abort", 64'(ph_total - start_cnt), 64'd0);

        // recovery after hold released
        reg_wr(A_CFG, 16'h0000);
        do_write(8'hFF, 8'hFF, 16'hFFFF, 6);
        do_read(8'h00, 8'h00, 16'h0001);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule